// File: doc/BRIEF.md
# Prescaled Timer/Counter with Buffered High Byte

This block is a byte-wide, bus-attached timer/counter for a small processor. Its count source is either a per-instruction tick strobe or an external pin whose edges are synchronised on the block clock first. An 8-bit prescaler can be switched in front of the counter. The counter runs either as an 8-bit or as a 16-bit value. A single control register selects the run state, width, source, edge polarity, prescaler bypass and divide ratio.

Software never touches the counter's upper byte directly. It goes through a buffer register. Reading the low byte captures the live upper byte into the buffer. Writing the low byte loads the buffer into the upper byte on the same edge. Both 16-bit reads and 16-bit writes are therefore coherent. A write to the counter holds off counting for two ticks and clears the hidden prescaler. A wrap past the top value sets a sticky flag, which raises the interrupt request when it is enabled.

Top module: `tmr_unit`

## Requirements
- R1: After reset the control register reads 0xFF, the high buffer reads 0x00, the status register reads 0x00 and `irq` is 0.
- R2: Register addresses are 0 for the low byte, 1 for the high buffer, 2 for control and 3 for status. Control bit 7 is run, bit 6 selects 8-bit width, bit 5 selects the pin as source, bit 4 selects the falling edge, bit 3 bypasses the prescaler, and bits 2:0 give the ratio. In timer mode with bypass, the count advances by one on each clock edge where `tickEn` is 1, and holds while `tickEn` is 0.
- R3: After a low-byte write, the next two `tickEn` ticks do not advance the count. The third tick does.
- R4: A low-byte write loads the counter with {high buffer, written byte} on one edge. A high-buffer write does not change the counter.
- R5: A low-byte read with `rdEn` returns the live low byte. On that edge it copies the live upper counter byte into the high buffer.
- R6: With the prescaler in use, the counter advances once per 2^(N+1) source events, where N is the ratio field (1:2 up to 1:256).
- R7: Every low-byte write clears the prescaler count and leaves the control register unchanged.
- R8: In pin mode, the count advances three clocks after a selected edge on `extPin`: rising when bit 4 is 0, falling when bit 4 is 1. The other edge is ignored.
- R9: The overflow flag (status bit 0) is set by a wrap from 0xFF to 0x00 in 8-bit mode, or from 0xFFFF to 0x0000 in 16-bit mode. A low-byte carry in 16-bit mode does not set it.
- R10: The flag is sticky. Writing 0 to status bit 0 clears it and writing 1 leaves it. An overflow on the same edge as a clearing write leaves the flag set.
- R11: `irq` is 1 exactly when the flag and the interrupt enable (status bit 1) are both 1.
- R12: While the run bit is 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Instruction-cycle tick strobe |
| extPin | input | 1 | Asynchronous external count input |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effect on low byte) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Two events can meet on one clock edge: a counter wrap that sets the overflow flag, and a software write that clears the flag. The bench puts the 8-bit counter at 0xFF and then issues the status write of 0 so that it lands on the wrapping edge. It judges the outcome from the status register read back afterwards. The flag must still be set, and a later write on its own must clear it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_HIBUF = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } tmr_reg_e;

  typedef struct packed {
    logic       run;
    logic       mode8;
    logic       srcExt;
    logic       edgeFall;
    logic       preBypass;
    logic [2:0] ratio;
  } tmr_cfg_t;

  typedef struct packed {
    logic wrLow;
    logic rdLow;
    logic wrHi;
    logic wrStat;
  } tmr_stb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [BW-1:0] wrData,
  input  logic [BW-1:0] cntLow,
  input  logic [BW-1:0] hiBuf,
  input  logic          ovfFlag,
  output tmr_stb_t      stb,
  output tmr_cfg_t      cfg,
  output logic          irqEn,
  output logic [BW-1:0] rdData
);
  tmr_reg_e regSel;
  assign regSel = tmr_reg_e'(addr);

  always_comb begin
    stb.wrLow  = wrEn && regSel == REG_LOW;
    stb.rdLow  = rdEn && !wrEn && regSel == REG_LOW;
    stb.wrHi   = wrEn && regSel == REG_HIBUF;
    stb.wrStat = wrEn && regSel == REG_STAT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg   <= '1;
      irqEn <= 1'b0;
    end else begin
      if (wrEn && regSel == REG_CTRL) cfg <= tmr_cfg_t'(wrData[7:0]);
      if (stb.wrStat) irqEn <= wrData[1];
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      REG_LOW:   rdData = cntLow;
      REG_HIBUF: rdData = hiBuf;
      REG_CTRL:  rdData[7:0] = cfg;
      REG_STAT:  rdData[1:0] = {irqEn, ovfFlag};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int BW       = BYTE_W,
  parameter int PRE_W    = 8,
  parameter int SYNC_N   = 2,
  parameter int HOLD_N   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  tmr_stb_t        stb,
  input  tmr_cfg_t        cfg,
  input  logic [BW-1:0]   wrData,
  input  logic            tickEn,
  input  logic            extPin,
  output logic [2*BW-1:0] count,
  output logic [BW-1:0]   hiBuf,
  output logic            ovfFlag
);
  localparam int CW    = 2 * BW;
  localparam int HOLDW = $clog2(HOLD_N + 1);

  logic [SYNC_N-1:0] syncQ;
  logic              prevQ;
  logic              pinNow;
  logic              edgeHit;

  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk) syncQ <= rstN ? extPin : 1'b0;
    end else begin : g_syncN
      always_ff @(posedge clk) syncQ <= rstN ? {syncQ[SYNC_N-2:0], extPin} : '0;
    end
  endgenerate

  assign pinNow = syncQ[SYNC_N-1];
  always_ff @(posedge clk) prevQ <= rstN ? pinNow : 1'b0;
  assign edgeHit = cfg.edgeFall ? (prevQ & ~pinNow) : (pinNow & ~prevQ);

  logic [HOLDW-1:0] holdQ;
  logic [PRE_W-1:0] preQ;
  logic [PRE_W:0]   preFull;
  logic [PRE_W-1:0] preMask;
  logic             rawEvt, evt, incNow, wrapNow;

  assign rawEvt  = cfg.srcExt ? edgeHit : tickEn;
  assign evt     = rawEvt && cfg.run && holdQ == '0;
  assign preFull = ((PRE_W+1)'(1) << ({1'b0, cfg.ratio} + 4'd1)) - (PRE_W+1)'(1);
  assign preMask = preFull[PRE_W-1:0];
  assign incNow  = evt && (cfg.preBypass || (preQ & preMask) == preMask);
  assign wrapNow = incNow && !stb.wrLow &&
                   (cfg.mode8 ? count[BW-1:0] == '1 : count == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
      preQ  <= '0;
      count <= '0;
      hiBuf <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (stb.wrLow)                  holdQ <= HOLDW'(HOLD_N);
      else if (tickEn && holdQ != '0) holdQ <= holdQ - 1'b1;

      if (stb.wrLow)                       preQ <= '0;
      else if (evt && !cfg.preBypass)      preQ <= preQ + 1'b1;

      if (stb.wrLow)    count <= {hiBuf, wrData};
      else if (incNow) begin
        if (cfg.mode8)  count[BW-1:0] <= count[BW-1:0] + 1'b1;
        else            count <= count + 1'b1;
      end

      if (stb.wrHi)       hiBuf <= wrData;
      else if (stb.rdLow) hiBuf <= count[CW-1:BW];

      if (wrapNow)         ovfFlag <= 1'b1;
      else if (stb.wrStat) ovfFlag <= ovfFlag & wrData[0];
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int SYNC_N = 2,
  parameter int HOLD_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       extPin,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq
);
  tmr_stb_t    stb;
  tmr_cfg_t    cfg;
  logic        irqEn;
  logic [15:0] cntVal;
  logic [7:0]  hiBufVal;
  logic        ovfFlag;

  tmr_ctrl #(.BW(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .cntLow(cntVal[7:0]), .hiBuf(hiBufVal),
    .ovfFlag(ovfFlag), .stb(stb), .cfg(cfg), .irqEn(irqEn), .rdData(rdData)
  );

  tmr_dp #(.BW(8), .PRE_W(PRE_W), .SYNC_N(SYNC_N), .HOLD_N(HOLD_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .wrData(wrData),
    .tickEn(tickEn), .extPin(extPin), .count(cntVal), .hiBuf(hiBufVal),
    .ovfFlag(ovfFlag)
  );

  assign irq = ovfFlag & irqEn;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  addr,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  wrData,
  input logic [15:0] cntVal,
  input logic [7:0]  hiBufVal,
  input logic        ovfFlag,
  input logic        runBit,
  input logic        irq
);
  logic wrLow, wrStat, rdLow;
  assign wrLow  = wrEn && addr == 2'd0;
  assign wrStat = wrEn && addr == 2'd3;
  assign rdLow  = rdEn && !wrEn && addr == 2'd0;

  a_r4_load_atomic: assert property (@(posedge clk) disable iff (!rstN)
    wrLow |=> cntVal == {$past(hiBufVal), $past(wrData)});

  a_r3_hold_first: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrLow) && !wrLow) |=> $stable(cntVal));

  a_r3_hold_second: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrLow, 2) && !$past(wrLow) && !wrLow) |=> $stable(cntVal));

  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    rdLow |=> hiBufVal == $past(cntVal[15:8]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !wrStat) |=> ovfFlag);

  a_r12_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !wrLow) |=> $stable(cntVal));

  a_r11_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ovfFlag);
endmodule

bind tmr_unit tmr_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .cntVal(cntVal), .hiBufVal(hiBufVal),
  .ovfFlag(ovfFlag), .runBit(cfg.run), .irq(irq)
);

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       extPin = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_unit u0 (.clk(clk), .rstN(rstN), .tickEn(tickEn), .extPin(extPin),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdData;
  endtask

  task automatic read16(output logic [15:0] v);
    addr = 2'd0; rdEn = 1'b1; #1 v[7:0] = rdData;
    @(negedge clk);
    rdEn = 1'b0; addr = 2'd1; #1 v[15:8] = rdData;
  endtask

  task automatic tReset();
    logic [7:0] d;
    rdReg(2'd2, d); check("R1 ctrl", d, 8'hFF);
    rdReg(2'd1, d); check("R1 hibuf", d, 8'h00);
    rdReg(2'd3, d); check("R1 status", d, 8'h00);
    check("R1 irq", irq, 0);
  endtask

  task automatic tLoadHold();
    logic [7:0] d; logic [15:0] v;
    busWr(2'd2, 8'h88);
    busWr(2'd1, 8'h12);
    busWr(2'd0, 8'h34);
    rdReg(2'd0, d); check("R4 load low", d, 8'h34);
    waitN(1); rdReg(2'd0, d); check("R3 held tick1", d, 8'h34);
    waitN(1); rdReg(2'd0, d); check("R3 held tick2", d, 8'h34);
    waitN(1); rdReg(2'd0, d); check("R3 third tick", d, 8'h35);
    busWr(2'd1, 8'h77);
    read16(v); check("R4 hibuf write no effect", v, 16'h1236);
  endtask

  task automatic tTickGate();
    logic [7:0] d;
    busWr(2'd0, 8'h10);
    waitN(2);
    tickEn = 1'b0;
    waitN(3); rdReg(2'd0, d); check("R2 no tick hold", d, 8'h10);
    tickEn = 1'b1;
    waitN(1); rdReg(2'd0, d); check("R2 tick one", d, 8'h11);
    waitN(1); rdReg(2'd0, d); check("R2 tick two", d, 8'h12);
  endtask

  task automatic tSnapshot();
    logic [15:0] v;
    busWr(2'd2, 8'h88);
    busWr(2'd1, 8'hAB);
    busWr(2'd0, 8'hFE);
    read16(v); check("R5 read a", v, 16'hABFE);
    waitN(2);
    read16(v); check("R5 read b", v, 16'hABFF);
    waitN(1);
    read16(v); check("R5 read carry", v, 16'hAC01);
  endtask

  task automatic tPrescale();
    logic [15:0] v; logic [7:0] d;
    busWr(2'd1, 8'h00);
    busWr(2'd2, 8'h80);
    busWr(2'd0, 8'h00);
    waitN(3); rdReg(2'd0, d); check("R6 div2 before", d, 0);
    waitN(1); rdReg(2'd0, d); check("R6 div2 first", d, 1);
    waitN(2); rdReg(2'd0, d); check("R6 div2 second", d, 2);
    busWr(2'd2, 8'h81);
    busWr(2'd0, 8'h00);
    waitN(5); rdReg(2'd0, d); check("R6 div4 before", d, 0);
    waitN(1); rdReg(2'd0, d); check("R6 div4 first", d, 1);
    waitN(4); rdReg(2'd0, d); check("R6 div4 second", d, 2);
    busWr(2'd0, 8'h00);
    waitN(5);
    busWr(2'd0, 8'h00);
    waitN(5); rdReg(2'd0, d); check("R7 prescaler cleared", d, 0);
    waitN(1); rdReg(2'd0, d); check("R7 count after clear", d, 1);
    rdReg(2'd2, d); check("R7 ctrl kept", d, 8'h81);
    busWr(2'd2, 8'h87);
    busWr(2'd0, 8'h00);
    waitN(257); read16(v); check("R6 div256 before", v, 0);
    read16(v); check("R6 div256 first", v, 1);
  endtask

  task automatic tExtPin();
    logic [7:0] d;
    busWr(2'd2, 8'hA8);
    busWr(2'd0, 8'h00);
    waitN(3);
    extPin = 1'b1;
    waitN(2); rdReg(2'd0, d); check("R8 rise latency", d, 0);
    waitN(1); rdReg(2'd0, d); check("R8 rise counted", d, 1);
    extPin = 1'b0;
    waitN(5); rdReg(2'd0, d); check("R8 fall ignored", d, 1);
    busWr(2'd2, 8'hB8);
    extPin = 1'b1;
    waitN(5); rdReg(2'd0, d); check("R8 rise ignored", d, 1);
    extPin = 1'b0;
    waitN(2); rdReg(2'd0, d); check("R8 fall latency", d, 1);
    waitN(1); rdReg(2'd0, d); check("R8 fall counted", d, 2);
  endtask

  task automatic tOverflow();
    logic [7:0] d;
    busWr(2'd2, 8'hC8);
    busWr(2'd0, 8'hFE);
    waitN(3); rdReg(2'd3, d); check("R9 no flag at FF", d, 0);
    waitN(1); rdReg(2'd3, d); check("R9 8-bit wrap", d, 1);
    check("R11 irq masked", irq, 0);
    busWr(2'd3, 8'h03);
    check("R11 irq on", irq, 1);
    rdReg(2'd3, d); check("R10 write one keeps", d, 8'h03);
    busWr(2'd3, 8'h02);
    rdReg(2'd3, d); check("R10 clear", d, 8'h02);
    check("R11 irq off", irq, 0);
    busWr(2'd2, 8'h88);
    busWr(2'd1, 8'h00);
    busWr(2'd0, 8'hFE);
    waitN(4); rdReg(2'd3, d); check("R9 low carry no flag", d, 8'h02);
    busWr(2'd1, 8'hFF);
    busWr(2'd0, 8'hFE);
    waitN(3); rdReg(2'd3, d); check("R9 no flag at FFFF", d, 8'h02);
    waitN(1); rdReg(2'd3, d); check("R9 16-bit wrap", d, 8'h03);
    check("R11 irq 16-bit", irq, 1);
    busWr(2'd2, 8'hC8);
    busWr(2'd0, 8'hFE);
    waitN(3);
    busWr(2'd3, 8'h02);
    rdReg(2'd3, d); check("R10 set beats clear", d, 8'h03);
    busWr(2'd3, 8'h02);
    rdReg(2'd3, d); check("R10 later clear", d, 8'h02);
  endtask

  task automatic tRunOff();
    logic [7:0] d;
    busWr(2'd2, 8'h08);
    busWr(2'd0, 8'h40);
    waitN(6); rdReg(2'd0, d); check("R12 stopped", d, 8'h40);
    busWr(2'd2, 8'h88);
    rdReg(2'd0, d); check("R12 restart edge", d, 8'h40);
    waitN(1); rdReg(2'd0, d); check("R12 running", d, 8'h41);
  endtask

  initial begin
    waitN(4);
    rstN = 1'b1;
    waitN(1);
    tReset();
    tLoadHold();
    tTickGate();
    tSnapshot();
    tPrescale();
    tExtPin();
    tOverflow();
    tRunOff();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule